// File: doc/BRIEF.md
# Input Change Interrupt Generator

This block watches a bank of already-synchronized pin levels and asks a host for attention whenever an input pin no longer matches the value that was captured the last time the host read the pins. The host's read of the pin register arrives as a one-cycle strobe. On that strobe the block copies every pin level into a snapshot register. A pin whose direction bit marks it as an input and whose level differs from its snapshot bit raises the interrupt. Pins set as outputs take no part in the comparison.

The interrupt is a level comparison, not a latched event. It therefore clears on its own when the pin goes back to its snapshot value, and it also clears after a read, because the read refreshes the snapshot. The output is a drive-low enable for an external open-drain pad: a 1 means the shared interrupt line is pulled low. Changing a pin from output to input while its level differs from the snapshot raises the interrupt at once. This is deliberate and is not masked.

Top module: `pin_change_irq`

## Requirements
- R1: Synchronous reset (rst_n low at a rising edge) loads snap_q with the pin levels present at that edge. After reset is released, irq_pull_low is 0 while the pins are unchanged.
- R2: irq_pull_low is 1 in the same cycle (combinationally) whenever some bit i has dir_in[i]=1 and pin_lvl[i] differs from snap_q[i].
- R3: When every input-configured pin returns to its snapshot value, irq_pull_low returns to 0 with no read.
- R4: A rising edge with snap_rd=1 loads snap_q with all pin_lvl bits, including pins configured as outputs. If the pins are then held, irq_pull_low is 0 after that edge.
- R5: A bit with dir_in[i]=0 (output) never causes irq_pull_low, whatever its pin level.
- R6: Setting dir_in[i] from 0 to 1 while pin_lvl[i] differs from snap_q[i] raises irq_pull_low in the same cycle.
- R7: snap_q keeps its value on every edge where snap_rd=0, even while the pins change.
- R8: irq_pull_low is 0 while rst_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; loads the snapshot from the pins |
| pin_lvl | input | WIDTH | Synchronized pin levels |
| dir_in | input | WIDTH | Per-pin direction: 1 = input, 0 = output |
| snap_rd | input | 1 | One-cycle strobe marking a read of the pin register |
| irq_pull_low | output | 1 | 1 = pull the open-drain interrupt line low |
| snap_q | output | WIDTH | Current captured snapshot of the pins |

## Verification
The assertions assume that pin_lvl, dir_in and snap_rd are free of glitches and stable around each rising edge, which holds because they come from synchronizers and a register-read decoder. They also assume that reset is held for at least one rising edge so the snapshot gets loaded. The bench meets these assumptions by changing every input only at falling edges, by asserting reset across several rising edges, and by holding each strobe for exactly one cycle.

// File: rtl/pin_change_irq.sv
module pin_change_irq #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_lvl,
  input  logic [WIDTH-1:0] dir_in,
  input  logic             snap_rd,
  output logic             irq_pull_low,
  output logic [WIDTH-1:0] snap_q
);

  logic [WIDTH-1:0] diff_in;

  always_ff @(posedge clk) begin
    if (!rst_n || snap_rd) snap_q <= pin_lvl;
  end

  assign diff_in      = (pin_lvl ^ snap_q) & dir_in;
  assign irq_pull_low = rst_n && (|diff_in);

  a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
    snap_rd |=> (snap_q == $past(pin_lvl)));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_rd |=> $stable(snap_q));

  a_r5_outputs_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_in == '0) |-> !irq_pull_low);

  a_r3_clear_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(snap_rd) && $stable(pin_lvl)) |-> !irq_pull_low);

  a_r8_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> !irq_pull_low);

endmodule

// File: tb/tb_pin_change_irq.sv
module tb_pin_change_irq;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] pin_lvl = '0;
  logic [W-1:0] dir_in = '1;
  logic snap_rd = 1'b0;
  logic irq_pull_low;
  logic [W-1:0] snap_q;

  int n_chk = 0;
  int n_bad = 0;
  logic [W-1:0] exp_snap;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_change_irq #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .dir_in(dir_in),
    .snap_rd(snap_rd), .irq_pull_low(irq_pull_low), .snap_q(snap_q)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic exp_irq();
    return |((pin_lvl ^ exp_snap) & dir_in);
  endfunction

  task automatic settle();
    #1;
  endtask

  task automatic do_read();
    @(negedge clk);
    snap_rd = 1'b1;
    @(posedge clk);
    exp_snap = pin_lvl;
    @(negedge clk);
    snap_rd = 1'b0;
    settle();
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    dir_in = '1;
    pin_lvl = 8'h5A;
    @(negedge clk); settle();
    check("R8", {7'd0, irq_pull_low}, 8'd0);
    pin_lvl = 8'hA5;
    settle();
    check("R8", {7'd0, irq_pull_low}, 8'd0);
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    exp_snap = 8'hA5;
    settle();
    check("R1", snap_q, 8'hA5);
    check("R1", {7'd0, irq_pull_low}, 8'd0);
  endtask

  task automatic t_raise_and_return();
    @(negedge clk);
    pin_lvl = pin_lvl ^ 8'h08;
    settle();
    check("R2", {7'd0, irq_pull_low}, {7'd0, exp_irq()});
    @(negedge clk);
    pin_lvl = pin_lvl ^ 8'h08;
    settle();
    check("R3", {7'd0, irq_pull_low}, 8'd0);
  endtask

  task automatic t_read_clears();
    @(negedge clk);
    pin_lvl = pin_lvl ^ 8'h81;
    settle();
    check("R2", {7'd0, irq_pull_low}, 8'd1);
    do_read();
    check("R4", snap_q, exp_snap);
    check("R4", {7'd0, irq_pull_low}, 8'd0);
  endtask

  task automatic t_hold();
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      pin_lvl = pin_lvl + 8'h13;
      settle();
      check("R7", snap_q, exp_snap);
      check("R2", {7'd0, irq_pull_low}, {7'd0, exp_irq()});
    end
    @(negedge clk);
    pin_lvl = exp_snap;
    settle();
    check("R3", {7'd0, irq_pull_low}, 8'd0);
  endtask

  task automatic t_outputs_and_switch();
    @(negedge clk);
    dir_in = 8'h0F;
    pin_lvl = pin_lvl ^ 8'hF0;
    settle();
    check("R5", {7'd0, irq_pull_low}, 8'd0);
    @(negedge clk);
    dir_in = 8'h00;
    pin_lvl = ~exp_snap;
    settle();
    check("R5", {7'd0, irq_pull_low}, 8'd0);
    @(negedge clk);
    pin_lvl = exp_snap ^ 8'h40;
    dir_in = 8'h0F;
    settle();
    check("R5", {7'd0, irq_pull_low}, 8'd0);
    @(negedge clk);
    dir_in = 8'h4F;
    settle();
    check("R6", {7'd0, irq_pull_low}, 8'd1);
    @(negedge clk);
    dir_in = 8'h0F;
    settle();
    do_read();
    check("R4", snap_q, exp_snap);
    check("R4", {7'd0, irq_pull_low}, 8'd0);
    @(negedge clk);
    dir_in = 8'hFF;
    settle();
    check("R6", {7'd0, irq_pull_low}, 8'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_raise_and_return();
    t_read_clears();
    t_hold();
    t_outputs_and_switch();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule